// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over a fixed number of clock cycles and returns a 64-bit product. A single-cycle start request, accepted only while the block is idle, captures both operands. A small controller then runs one conditional-add-and-shift step per clock, once for each multiplier bit, and flags completion with a one-cycle done pulse.

The datapath is kept narrow. The multiplicand sits in a 32-bit register, and a single 32-bit adder is used. The 64-bit product register starts with the multiplier in its lower half and zero in its upper half. On each step the register's least significant bit decides whether the multiplicand is added to the upper half. The whole register, with the adder's carry on top, then moves right by one place. The partial product thus grows downward into the space freed by the consumed multiplier bits.

Top module: `shift_add_mult`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, product_o is 0 and done_o is 0.
- R2: After a multiplication completes, product_o equals the unsigned 64-bit product of the a_i and b_i values sampled with the accepted start.
- R3: If start_i is sampled high in idle at clock edge k, done_o is high between edges k+32 and k+33 and is low in every other cycle of that operation.
- R4: A start_i sampled while a multiplication is running, or during the done cycle, is ignored. The result and the operands in use are unchanged.
- R5: While idle with start_i low, product_o holds its value regardless of a_i and b_i.
- R6: In the cycle after an accepted start, product_o equals {32'h0, b_i} (upper half zero, multiplier in the lower half).
- R7: The adder's carry is kept, so 32'hFFFFFFFF times 32'hFFFFFFFF yields 64'hFFFFFFFE00000001.
- R8: A zero in either operand yields a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication (accepted when idle) |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| product_o | output | 64 | Product register contents |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following:
- the done pulse is a single cycle wide and arrives only after exactly 32 counted steps;
- the result at done matches a product of the captured operands;
- the register shows {0, b} right after a load;
- the product holds while idle;
- the multiplicand cannot be replaced while a multiplication is in flight.

Only the bench's scenarios show certain specific cases. These are the carry-heavy all-ones case, zero operands, the exact cycle the pulse lands relative to the start request, and the effect of a start request placed in mid-run or in the done cycle.

// File: rtl/mult_pkg.sv
package mult_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/mult_ctrl.sv
module mult_ctrl
  import mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output state_e state_o,
  output logic   load_o,
  output logic   step_o,
  output logic   done_o
);
  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign state_o = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [WIDTH-1:0]   mcand_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q;
  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] addend;

  // multiplier bit lives in prod_q[0]
  assign addend = prod_q[0] ? mcand_q : '0;
  assign sum    = {1'b0, prod_q[PW-1:WIDTH]} + {1'b0, addend};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      prod_q  <= {{WIDTH{1'b0}}, b_i};
    end else if (step_i) begin
      // carry lands in bit PW-1, consumed bit drops off
      prod_q  <= {sum, prod_q[WIDTH-1:1]};
    end
  end

  assign mcand_o   = mcand_q;
  assign product_o = prod_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult
  import mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] product_o,
  output logic               done_o
);
  state_e           state_q;
  logic             load_w;
  logic             step_w;
  logic [WIDTH-1:0] mcand_w;

  mult_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state_q),
    .load_o  (load_w),
    .step_o  (step_w),
    .done_o  (done_o)
  );

  mult_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_w),
    .step_i    (step_w),
    .a_i       (a_i),
    .b_i       (b_i),
    .mcand_o   (mcand_w),
    .product_o (product_o)
  );
endmodule

// File: rtl/mult_checker.sv
module mult_checker
  import mult_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [WIDTH-1:0]   a_i,
  input logic [WIDTH-1:0]   b_i,
  input logic [2*WIDTH-1:0] product_i,
  input logic               done_i,
  input state_e             state_i,
  input logic [WIDTH-1:0]   mcand_i
);
  localparam int PW = 2 * WIDTH;
  localparam int CW = $clog2(WIDTH) + 2;

  logic [CW-1:0]    steps_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic             accept;

  assign accept = (state_i == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steps_q <= '0;
      a_q     <= '0;
      b_q     <= '0;
    end else if (accept) begin
      steps_q <= '0;
      a_q     <= a_i;
      b_q     <= b_i;
    end else if (state_i == ST_RUN) begin
      steps_q <= steps_q + 1'b1;
    end
  end

  assert_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> product_i == (PW'(a_q) * PW'(b_q)));

  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> steps_q == CW'(WIDTH));

  assert_busy_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE && start_i) |=> $stable(mcand_i));

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && !start_i) |=> $stable(product_i));

  assert_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> product_i == {{WIDTH{1'b0}}, $past(b_i)});
endmodule

bind shift_add_mult mult_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .product_i (product_o),
  .done_i    (done_o),
  .state_i   (state_q),
  .mcand_i   (mcand_w)
);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;
  localparam int W = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic [2*W-1:0] product_o;
  logic          done_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  shift_add_mult #(.WIDTH(W)) u_shift_add_mult (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .product_o (product_o),
    .done_o    (done_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue start at a negedge; returns at the negedge after the load edge
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    start_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done_o && cycles < 100) begin
      @(negedge clk_i);
      cycles++;
    end
  endtask

  task automatic test_reset();
    check(product_o == '0, "R1 reset product", product_o, 0);
    check(done_o == 1'b0, "R1 reset done", 64'(done_o), 0);
  endtask

  task automatic test_mult(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    int cyc;
    logic [63:0] exp;
    exp = 64'(a) * 64'(b);
    issue(a, b);
    check(product_o == {32'h0, b}, "R6 load image", product_o, {32'h0, b});
    check(done_o == 1'b0, "R3 no early done", 64'(done_o), 0);
    wait_done(cyc);
    check(cyc == 32, "R3 latency", 64'(cyc), 32);
    check(product_o == exp, req, product_o, exp);
    @(negedge clk_i);
    check(done_o == 1'b0, "R3 single pulse", 64'(done_o), 0);
    check(product_o == exp, "R5 hold after done", product_o, exp);
  endtask

  task automatic test_idle_hold();
    logic [63:0] snap;
    snap = product_o;
    for (int i = 0; i < 8; i++) begin
      a_i = 32'h1357_0000 + 32'(i); b_i = ~a_i;
      @(negedge clk_i);
      check(product_o == snap && !done_o, "R5 idle hold", product_o, snap);
    end
  endtask

  task automatic test_busy_start();
    int cyc;
    logic [63:0] exp;
    exp = 64'(32'd1000) * 64'(32'd777);
    issue(32'd1000, 32'd777);
    repeat (5) @(negedge clk_i);
    start_i = 1'b1; a_i = 32'hDEAD_BEEF; b_i = 32'h1234_5678;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(cyc);
    check(cyc == 32 - 6, "R4 timing unaffected", 64'(cyc), 26);
    check(product_o == exp, "R4 mid-run start ignored", product_o, exp);
    // start during the done cycle
    start_i = 1'b1; a_i = 32'h5; b_i = 32'h7;
    @(negedge clk_i);
    start_i = 1'b0;
    check(product_o == exp, "R4 done-cycle start ignored", product_o, exp);
    @(negedge clk_i);
    check(product_o == exp && !done_o, "R4 still idle", product_o, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    test_reset();
    test_mult(32'd6, 32'd7, "R2 small product");
    test_mult(32'h0001_0000, 32'h0001_0000, "R2 power of two");
    test_mult(32'hA5A5_A5A5, 32'h5A5A_5A5A, "R2 alternating bits");
    test_mult(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7 carry all ones");
    test_mult(32'h0, 32'hFFFF_FFFF, "R8 zero multiplicand");
    test_mult(32'h8765_4321, 32'h0, "R8 zero multiplier");
    test_idle_hold();
    test_busy_start();
    test_mult(32'h8000_0001, 32'hFFFF_FFFE, "R2 after ignored start");
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule